// File: doc/BRIEF.md
# Sample-Capture Sequencer

This block is the control state machine of a logic-analyser capture engine. Software programs a total sample count, a pre-trigger sample count, a sample-rate divisor and a store/stream mode. It then writes a run command. The engine first takes the pre-trigger samples and then idles until the trigger matcher reports a hit. After the hit it takes the remaining samples and stops in a done phase. Each phase drives its own 16-bit status code, so that a polling host can follow the capture.

Samples are paced by a divider. The divider counts pulses of a base-rate enable and takes one sample on every D-th pulse. Each sample raises a write strobe toward either the memory path, with a write address, or the streaming path. When the capture finishes, the block latches three results: the number of samples taken, the number taken before the trigger, and the write position after the last stored sample. A halt command returns the machine to idle from any phase and leaves the latched results untouched.

Top module: `capseq_top`

## Requirements
- R1: After reset the status is 0x85E0 (idle), done_o is 0, both write strobes are 0 and all three result outputs are 0.
- R2: A command byte 0x03 accepted in idle or done clears the sample counters and the write address to 0 and enters the pre-sample phase (status 0x85E2) on the next cycle. If the programmed pre-trigger count is 0, it enters the wait-trigger phase (status 0x85EA) instead.
- R3: A command byte 0x00 returns the machine to idle (0x85E0) on the next cycle from any phase and leaves the result outputs unchanged. Any other command byte, and a 0x03 received in the pre-sample, wait-trigger or run phase, has no effect.
- R4: In the pre-sample and run phases, a sample is taken on every D-th cycle in which sample_en_i is high, counted from phase entry. D is rate_div_i, and a divisor of 0 acts as 1. The write strobe is high in the same cycle as that D-th pulse.
- R5: The pre-sample phase takes exactly pre_cnt_i samples and then moves to wait-trigger. trig_hit_i has no effect during the pre-sample phase.
- R6: In wait-trigger no sample is taken and the divider holds. A trig_hit_i pulse moves the machine to run (status 0x85EE), or straight to done if the samples already taken are not fewer than total_cnt_i.
- R7: The run phase takes samples until the total taken equals total_cnt_i, then enters done (status 0x85ED). done_o is high exactly while the status is 0x85ED.
- R8: On entry to done, res_total_o takes the total samples taken and res_pre_o the samples taken in the pre-sample phase. res_wpos_o takes the write address after the last stored sample (zero-extended), which is 0 in streaming mode. The results change at no other time.
- R9: mode_stream_i is captured at the start command. In mode 0 each sample pulses mem_we_o, with mem_addr_o holding the sample index starting at 0 and advancing by one after each write. In mode 1 each sample pulses stream_we_o and mem_addr_o stays at 0.
- R10: mem_we_o and stream_we_o are never high together, and neither is high outside the pre-sample and run phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_we_i | input | 1 | Command byte strobe |
| cmd_data_i | input | 8 | Command byte: 0x03 run, 0x00 halt |
| mode_stream_i | input | 1 | 0 store to memory, 1 stream |
| total_cnt_i | input | CNT_W | Programmed total sample count |
| pre_cnt_i | input | CNT_W | Programmed pre-trigger sample count |
| rate_div_i | input | DIV_W | Sample-rate divisor |
| sample_en_i | input | 1 | Base-rate sample enable pulse |
| trig_hit_i | input | 1 | Trigger matcher hit |
| status_o | output | 16 | Phase status code |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Memory write address |
| stream_we_o | output | 1 | Stream write strobe |
| done_o | output | 1 | Capture complete |
| res_total_o | output | CNT_W | Latched total samples |
| res_pre_o | output | CNT_W | Latched pre-trigger samples |
| res_wpos_o | output | CNT_W | Latched final write position |

## Verification
A wrong phase appears on status_o in the cycle after the edge that caused it. A wrong divider phase or sample count appears as a write strobe in the wrong cycle, so the fault shows on the first sample where it matters and never later than the end of that capture. Wrong counter values, and a wrong choice of memory or stream path, show at the latched results on the first cycle of done, and in mem_addr_o at every stored sample. The sweep covers every total from 0 to 4, every pre-trigger count up to one beyond the total, divisors 0 to 3 and both modes. A halt is also issued in the middle of the run phase.

// File: rtl/capseq_pkg.sv
package capseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRE  = 3'd1,
    ST_WAIT = 3'd2,
    ST_RUN  = 3'd3,
    ST_DONE = 3'd4
  } cs_state_e;

  localparam logic [15:0] CODE_IDLE = 16'h85E0;
  localparam logic [15:0] CODE_PRE  = 16'h85E2;
  localparam logic [15:0] CODE_WAIT = 16'h85EA;
  localparam logic [15:0] CODE_RUN  = 16'h85EE;
  localparam logic [15:0] CODE_DONE = 16'h85ED;

  localparam logic [7:0] CMD_RUN  = 8'h03;
  localparam logic [7:0] CMD_HALT = 8'h00;

  function automatic logic [15:0] status_of(cs_state_e s);
    logic [15:0] code;
    case (s)
      ST_PRE:  code = CODE_PRE;
      ST_WAIT: code = CODE_WAIT;
      ST_RUN:  code = CODE_RUN;
      ST_DONE: code = CODE_DONE;
      default: code = CODE_IDLE;
    endcase
    return code;
  endfunction

endpackage

// File: rtl/capseq_rate_div.sv
module capseq_rate_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] lim_m1;

  // divisor 0 behaves as divisor 1
  assign lim_m1 = (div_i == '0) ? '0 : div_i - 1'b1;
  assign tick_o = en_i && active_i && (cnt_q == lim_m1);

  always_comb begin
    cnt_d = cnt_q;
    if (!active_i) begin
      cnt_d = '0;
    end else if (en_i) begin
      cnt_d = tick_o ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

endmodule

// File: rtl/capseq_fsm.sv
module capseq_fsm
  import capseq_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      start_i,
  input  logic      halt_i,
  input  logic      trig_i,
  input  logic      tick_i,
  input  logic      pre_zero_i,
  input  logic      pre_last_i,
  input  logic      run_last_i,
  input  logic      reached_i,
  output cs_state_e state_o,
  output logic      start_ok_o,
  output logic      enter_done_o
);

  cs_state_e st_q, st_d;

  assign start_ok_o = start_i && (st_q == ST_IDLE || st_q == ST_DONE);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE, ST_DONE: if (start_ok_o) st_d = pre_zero_i ? ST_WAIT : ST_PRE;
      ST_PRE:           if (tick_i && pre_last_i) st_d = ST_WAIT;
      ST_WAIT:          if (trig_i) st_d = reached_i ? ST_DONE : ST_RUN;
      ST_RUN:           if (tick_i && run_last_i) st_d = ST_DONE;
      default:          st_d = ST_IDLE;
    endcase
    if (halt_i) st_d = ST_IDLE;
  end

  assign enter_done_o = (st_d == ST_DONE) && (st_q != ST_DONE);
  assign state_o      = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

endmodule

// File: rtl/capseq_counters.sv
module capseq_counters #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic              tick_i,
  input  logic              count_en_i,
  input  logic              in_pre_i,
  input  logic              enter_done_i,
  input  logic [CNT_W-1:0]  pre_cnt_i,
  input  logic [CNT_W-1:0]  total_cnt_i,
  output logic              mode_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              pre_last_o,
  output logic              run_last_o,
  output logic              reached_o,
  output logic [CNT_W-1:0]  res_total_o,
  output logic [CNT_W-1:0]  res_pre_o,
  output logic [CNT_W-1:0]  res_wpos_o
);

  logic [CNT_W-1:0]  samp_q, samp_d, samp_nxt;
  logic [CNT_W-1:0]  pre_q, pre_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              mode_q, mode_d;
  logic [CNT_W-1:0]  rtot_q, rtot_d, rpre_q, rpre_d, rpos_q, rpos_d;

  assign samp_nxt   = samp_q + 1'b1;
  assign pre_last_o = (samp_nxt == pre_cnt_i);
  assign run_last_o = (samp_nxt >= total_cnt_i);
  assign reached_o  = (samp_q >= total_cnt_i);

  always_comb begin
    samp_d = samp_q;
    pre_d  = pre_q;
    addr_d = addr_q;
    mode_d = mode_q;
    if (start_i) begin
      samp_d = '0;
      pre_d  = '0;
      addr_d = '0;
      mode_d = mode_i;
    end else if (tick_i && count_en_i) begin
      samp_d = samp_nxt;
      if (in_pre_i) pre_d  = pre_q + 1'b1;
      if (!mode_q)  addr_d = addr_q + 1'b1;
    end
  end

  always_comb begin
    rtot_d = rtot_q;
    rpre_d = rpre_q;
    rpos_d = rpos_q;
    if (enter_done_i) begin
      rtot_d = samp_d;
      rpre_d = pre_d;
      rpos_d = CNT_W'(addr_d);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_q <= '0;
      pre_q  <= '0;
      addr_q <= '0;
      mode_q <= 1'b0;
      rtot_q <= '0;
      rpre_q <= '0;
      rpos_q <= '0;
    end else begin
      samp_q <= samp_d;
      pre_q  <= pre_d;
      addr_q <= addr_d;
      mode_q <= mode_d;
      rtot_q <= rtot_d;
      rpre_q <= rpre_d;
      rpos_q <= rpos_d;
    end
  end

  assign mode_o      = mode_q;
  assign addr_o      = addr_q;
  assign res_total_o = rtot_q;
  assign res_pre_o   = rpre_q;
  assign res_wpos_o  = rpos_q;

endmodule

// File: rtl/capseq_top.sv
module capseq_top
  import capseq_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DIV_W  = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_we_i,
  input  logic [7:0]        cmd_data_i,
  input  logic              mode_stream_i,
  input  logic [CNT_W-1:0]  total_cnt_i,
  input  logic [CNT_W-1:0]  pre_cnt_i,
  input  logic [DIV_W-1:0]  rate_div_i,
  input  logic              sample_en_i,
  input  logic              trig_hit_i,
  output logic [15:0]       status_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              stream_we_o,
  output logic              done_o,
  output logic [CNT_W-1:0]  res_total_o,
  output logic [CNT_W-1:0]  res_pre_o,
  output logic [CNT_W-1:0]  res_wpos_o
);

  cs_state_e state;
  logic      start_cmd, halt_cmd, start_ok, enter_done;
  logic      tick, count_en, mode_q;
  logic      pre_last, run_last, reached;

  assign start_cmd = cmd_we_i && (cmd_data_i == CMD_RUN);
  assign halt_cmd  = cmd_we_i && (cmd_data_i == CMD_HALT);
  assign count_en  = (state == ST_PRE) || (state == ST_RUN);

  capseq_rate_div #(.DIV_W(DIV_W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (count_en),
    .en_i     (sample_en_i),
    .div_i    (rate_div_i),
    .tick_o   (tick)
  );

  capseq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_cmd),
    .halt_i       (halt_cmd),
    .trig_i       (trig_hit_i),
    .tick_i       (tick),
    .pre_zero_i   (pre_cnt_i == '0),
    .pre_last_i   (pre_last),
    .run_last_i   (run_last),
    .reached_i    (reached),
    .state_o      (state),
    .start_ok_o   (start_ok),
    .enter_done_o (enter_done)
  );

  capseq_counters #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_ok),
    .mode_i       (mode_stream_i),
    .tick_i       (tick),
    .count_en_i   (count_en),
    .in_pre_i     (state == ST_PRE),
    .enter_done_i (enter_done),
    .pre_cnt_i    (pre_cnt_i),
    .total_cnt_i  (total_cnt_i),
    .mode_o       (mode_q),
    .addr_o       (mem_addr_o),
    .pre_last_o   (pre_last),
    .run_last_o   (run_last),
    .reached_o    (reached),
    .res_total_o  (res_total_o),
    .res_pre_o    (res_pre_o),
    .res_wpos_o   (res_wpos_o)
  );

  assign status_o    = status_of(state);
  assign done_o      = (state == ST_DONE);
  assign mem_we_o    = tick && count_en && !mode_q;
  assign stream_we_o = tick && count_en && mode_q;

endmodule

// File: rtl/capseq_chk.sv
module capseq_chk #(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_we_i,
  input logic [7:0]        cmd_data_i,
  input logic [15:0]       status_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              stream_we_o,
  input logic              done_o,
  input logic [CNT_W-1:0]  res_total_o,
  input logic [CNT_W-1:0]  res_pre_o,
  input logic [CNT_W-1:0]  res_wpos_o
);

  p_we_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_we_o && stream_we_o));

  p_we_phase_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o || stream_we_o) |-> (status_o == 16'h85E2 || status_o == 16'h85EE));

  p_done_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o == (status_o == 16'h85ED));

  p_halt_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_data_i == 8'h00) |=> status_o == 16'h85E0);

  p_trig_pre_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o == 16'h85E2 && !mem_we_o && !stream_we_o && !cmd_we_i) |=> status_o == 16'h85E2);

  p_res_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(done_o) |-> ($stable(res_total_o) && $stable(res_pre_o) && $stable(res_wpos_o)));

  p_addr_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> mem_addr_o == $past(mem_addr_o) + 1'b1);

endmodule

bind capseq_top capseq_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_we_i    (cmd_we_i),
  .cmd_data_i  (cmd_data_i),
  .status_o    (status_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .stream_we_o (stream_we_o),
  .done_o      (done_o),
  .res_total_o (res_total_o),
  .res_pre_o   (res_pre_o),
  .res_wpos_o  (res_wpos_o)
);

// File: tb/capseq_top_tb_top.sv
module capseq_top_tb_top;

  localparam logic [15:0] S_IDLE = 16'h85E0;
  localparam logic [15:0] S_PRE  = 16'h85E2;
  localparam logic [15:0] S_WAIT = 16'h85EA;
  localparam logic [15:0] S_RUN  = 16'h85EE;
  localparam logic [15:0] S_DONE = 16'h85ED;

  logic        clk, rst_n;
  logic        cmd_we, mode_stream, sample_en, trig_hit;
  logic [7:0]  cmd_data;
  logic [31:0] total_cnt, pre_cnt;
  logic [15:0] rate_div;
  logic [15:0] status;
  logic        mem_we, stream_we, done;
  logic [15:0] mem_addr;
  logic [31:0] res_total, res_pre, res_wpos;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  bit finished = 0;

  capseq_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_data_i(cmd_data),
    .mode_stream_i(mode_stream), .total_cnt_i(total_cnt), .pre_cnt_i(pre_cnt),
    .rate_div_i(rate_div), .sample_en_i(sample_en), .trig_hit_i(trig_hit),
    .status_o(status), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .stream_we_o(stream_we), .done_o(done), .res_total_o(res_total),
    .res_pre_o(res_pre), .res_wpos_o(res_wpos)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // set inputs after a falling edge, return 5 ns later (before the rising edge)
  task automatic drive(input logic se, input logic trg, input logic cw, input logic [7:0] cd);
    @(negedge clk);
    sample_en = se;
    trig_hit  = trg;
    cmd_we    = cw;
    cmd_data  = cd;
    #5;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  // one sample: dd enable pulses, strobe expected on the last one (R4, R9)
  task automatic take_sample(input int dd, input int m, inout int taken);
    for (int j = 1; j <= dd; j++) begin
      logic w;
      drive(1'b1, 1'b0, 1'b0, 8'h00);
      w = (j == dd);
      check("R4 mem_we cadence", 32'(mem_we), 32'(w && m == 0));
      check("R9 stream_we cadence", 32'(stream_we), 32'(w && m == 1));
      if (w && m == 0) check("R9 write address", 32'(mem_addr), 32'(taken));
      if (w && m == 1) check("R9 address held in stream", 32'(mem_addr), 32'd0);
    end
    taken++;
  endtask

  task automatic run_cfg(input int t, input int p, input int d, input int m);
    int dd;
    int taken;
    dd = (d == 0) ? 1 : d;
    taken = 0;
    @(negedge clk);
    total_cnt = 32'(t); pre_cnt = 32'(p); rate_div = 16'(d); mode_stream = (m == 1);
    drive(1'b0, 1'b0, 1'b1, 8'h03);
    idle();
    check("R2 start phase", 32'(status), (p > 0) ? 32'(S_PRE) : 32'(S_WAIT));
    if (p > 0) begin
      drive(1'b0, 1'b1, 1'b0, 8'h00);
      idle();
      check("R5 trigger ignored in pre-sample", 32'(status), 32'(S_PRE));
    end
    for (int k = 0; k < p; k++) take_sample(dd, m, taken);
    idle();
    check("R5 wait after pre count", 32'(status), 32'(S_WAIT));
    for (int j = 0; j < dd; j++) begin
      drive(1'b1, 1'b0, 1'b0, 8'h00);
      check("R6 no write while waiting", 32'({mem_we, stream_we}), 32'd0);
    end
    drive(1'b0, 1'b0, 1'b1, 8'h55);
    drive(1'b0, 1'b0, 1'b1, 8'h03);
    idle();
    check("R3 stray and busy commands ignored", 32'(status), 32'(S_WAIT));
    drive(1'b0, 1'b1, 1'b0, 8'h00);
    idle();
    check("R6 trigger response", 32'(status), (taken >= t) ? 32'(S_DONE) : 32'(S_RUN));
    while (taken < t) take_sample(dd, m, taken);
    idle();
    check("R7 done status", 32'(status), 32'(S_DONE));
    check("R7 done flag", 32'(done), 32'd1);
    check("R8 total result", res_total, 32'(taken));
    check("R8 pre result", res_pre, 32'(p));
    check("R8 write position", res_wpos, (m == 1) ? 32'd0 : 32'(taken));
    drive(1'b0, 1'b0, 1'b1, 8'h00);
    idle();
    check("R3 halt from done", 32'(status), 32'(S_IDLE));
    check("R7 done flag clear", 32'(done), 32'd0);
    check("R3 results kept on halt", res_total, 32'(taken));
  endtask

  initial begin
    int tk;
    rst_n = 1'b0; cmd_we = 0; cmd_data = 0; mode_stream = 0; sample_en = 0; trig_hit = 0;
    total_cnt = 0; pre_cnt = 0; rate_div = 1;
    repeat (3) @(negedge clk);
    #5;
    check("R1 reset status", 32'(status), 32'(S_IDLE));
    check("R1 reset done", 32'(done), 32'd0);
    check("R1 reset strobes", 32'({mem_we, stream_we}), 32'd0);
    check("R1 reset results", res_total | res_pre | res_wpos, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int t = 0; t <= 4; t++)
      for (int p = 0; p <= t + 1; p++)
        for (int d = 0; d <= 3; d++)
          for (int m = 0; m < 2; m++)
            run_cfg(t, p, d, m);

    // halt in the middle of the run phase; previous results must stay
    run_cfg(2, 1, 1, 0);
    @(negedge clk);
    total_cnt = 3; pre_cnt = 1; rate_div = 1; mode_stream = 0;
    tk = 0;
    drive(1'b0, 1'b0, 1'b1, 8'h03);
    take_sample(1, 0, tk);
    drive(1'b0, 1'b1, 1'b0, 8'h00);
    take_sample(1, 0, tk);
    idle();
    check("R6 running after trigger", 32'(status), 32'(S_RUN));
    drive(1'b0, 1'b0, 1'b1, 8'h00);
    idle();
    check("R3 halt from run", 32'(status), 32'(S_IDLE));
    check("R3 total kept", res_total, 32'd2);
    check("R3 pre kept", res_pre, 32'd1);
    check("R3 wpos kept", res_wpos, 32'd2);

    // restart straight from done without a halt
    @(negedge clk);
    total_cnt = 1; pre_cnt = 0;
    tk = 0;
    drive(1'b0, 1'b0, 1'b1, 8'h03);
    drive(1'b0, 1'b1, 1'b0, 8'h00);
    take_sample(1, 0, tk);
    idle();
    check("R7 single sample done", 32'(status), 32'(S_DONE));
    total_cnt = 2; pre_cnt = 1;
    drive(1'b0, 1'b0, 1'b1, 8'h03);
    idle();
    check("R2 restart from done", 32'(status), 32'(S_PRE));
    check("R2 restart clears done", 32'(done), 32'd0);
    check("R2 address cleared", 32'(mem_addr), 32'd0);
    check("R8 results held until next done", res_total, 32'd1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule